// File: doc/BRIEF.md
# Configurable Two-Flop Logic Cell

A behavioural model of one programmable logic cell. A 32-bit lookup store computes two outputs, F and G, from five logic inputs and the cell's own register state. Two clock-enabled registers capture F, G or a direct data input. Two output multiplexers choose between the combinational and the registered value. Every choice is held in a static configuration word. The word is shifted in serially on its own clock and stays in place until it is reloaded.

The lookup store has three modes. In the split mode it forms two independent 4-input functions. In the wide mode it forms one 5-input function that drives both F and G. In the muxed mode one input selects between two 4-input functions. The register state can be fed back as a lookup input, so one cell can hold a small counter or a state bit without outside routing. The register clock edge, the use of the enable pin and the response to the direct clear pin are also set by configuration.

Top module: `lcell_top`

## Requirements
- R1: While `cfg_en_i` is high, each rising edge of `cfg_clk_i` shifts `cfg_data_i` into a 53-bit configuration word, most significant bit first. The word layout from bit 52 down is: mode[1:0], x_from_q, y_from_q, clk_fall, ce_used, rd_block, dx_src[1:0], dy_src[1:0], f_p[1:0], f_q[1:0], g_p[1:0], g_q[1:0], f_use_e, g_use_e, lut[31:0].
- R2: While `cfg_en_i` is low, pulses on `cfg_clk_i` leave the configuration word unchanged.
- R3: Mode 0 or 3 is the split mode. Input select codes are 0=B, 1=C, 2=QX, 3=QY. F is lut[{F4, sel(f_q), sel(f_p), A}], where F4 is E if f_use_e is set and D otherwise. G is lut[16 + {G4, sel(g_q), sel(g_p), A}], where G4 is E if g_use_e is set and D otherwise.
- R4: Mode 1 is the wide mode. F and G both equal lut[{E, D, sel(f_q), sel(f_p), A}].
- R5: Mode 2 is the muxed mode. F and G both equal lut[{D, sel(f_q), sel(f_p), A}] when E is 0, and lut[16 + {D, sel(g_q), sel(g_p), A}] when E is 1.
- R6: When ce_used is 1 and `ec_i` is 0, both registers hold their value across active clock edges. When ce_used is 0, `ec_i` has no effect and the registers load on every active edge.
- R7: The next value of register QX comes from dx_src, and the next value of QY comes from dy_src. The codes are 0=F, 1=G, and 2 or 3=`di_i`.
- R8: The registers update on the rising edge of `clk_i` when clk_fall is 0, and on the falling edge when clk_fall is 1.
- R9: `rd_i` high clears both registers at once, without waiting for a clock edge. When rd_block is 1, `rd_i` has no effect.
- R10: `rst_ni` low clears both registers at once, without waiting for a clock edge.
- R11: `x_o` shows QX when x_from_q is 1 and F when it is 0. `y_o` shows QY when y_from_q is 1 and G when it is 0.
- R12: While `cfg_done_i` is low, `x_o` and `y_o` are 0.
- R13: Choosing QX or QY as a lookup input feeds the current register state back into F and G. A configuration with F equal to the inverse of QX, loaded into QX, makes QX toggle on every enabled active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Global asynchronous clear of the registers, active low |
| cfg_clk_i | input | 1 | Configuration shift clock |
| cfg_en_i | input | 1 | Shift enable for the configuration word |
| cfg_data_i | input | 1 | Serial configuration data, MSB first |
| cfg_done_i | input | 1 | Configuration complete; outputs are held at 0 while low |
| a_i | input | 1 | Logic input A |
| b_i | input | 1 | Logic input B |
| c_i | input | 1 | Logic input C |
| d_i | input | 1 | Logic input D |
| e_i | input | 1 | Logic input E |
| di_i | input | 1 | Direct data input to the registers |
| ec_i | input | 1 | Register clock enable |
| rd_i | input | 1 | Direct asynchronous clear, active high |
| x_o | output | 1 | Output X (F or QX) |
| y_o | output | 1 | Output Y (G or QY) |

## Verification
The register assertions assume the configuration word is steady while the registers are out of reset. A change to the edge-polarity bit moves the effective clock, and a change to the enable or source bits changes what an edge captures. The bench therefore loads every configuration word with `rst_ni` held low and releases reset only after loading ends. The assertions also assume that `di_i`, `ec_i` and `rd_i` never change on an active edge. The bench drives all inputs 2 ns or 5 ns after a rising edge, which keeps them clear of both the rising and the falling edge in either polarity. The configuration-hold property is active only outside reset, so the bench pulses the shift clock with the enable low after reset has been released.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  parameter int unsigned LUT_BITS = 32;
  localparam int unsigned LUT_AW  = $clog2(LUT_BITS);
  localparam int unsigned HALF_AW = LUT_AW - 1;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE  = 2'd1,
    MODE_MUXED = 2'd2,
    MODE_SPLIT_ALT = 2'd3
  } lut_mode_e;

  typedef enum logic [1:0] {
    SRC_B  = 2'd0,
    SRC_C  = 2'd1,
    SRC_QX = 2'd2,
    SRC_QY = 2'd3
  } in_src_e;

  typedef enum logic [1:0] {
    DSRC_F  = 2'd0,
    DSRC_G  = 2'd1,
    DSRC_DI = 2'd2,
    DSRC_DI_ALT = 2'd3
  } d_src_e;

  // field order is the shift order (first field shifted lands at MSB)
  typedef struct packed {
    lut_mode_e           mode;
    logic                x_from_q;
    logic                y_from_q;
    logic                clk_fall;
    logic                ce_used;
    logic                rd_block;
    d_src_e              dx_src;
    d_src_e              dy_src;
    in_src_e             f_p;
    in_src_e             f_q;
    in_src_e             g_p;
    in_src_e             g_q;
    logic                f_use_e;
    logic                g_use_e;
    logic [LUT_BITS-1:0] lut;
  } cell_cfg_t;

  localparam int unsigned CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int unsigned W = 53
) (
  input  logic         cfg_clk_i,
  input  logic         rst_ni,
  input  logic         cfg_en_i,
  input  logic         cfg_data_i,
  output logic [W-1:0] word_o
);
  // configuration memory is not cleared by the register reset
  logic [W-1:0] sr_q;

  always_ff @(posedge cfg_clk_i) begin
    if (cfg_en_i) sr_q <= {sr_q[W-2:0], cfg_data_i};
  end

  assign word_o = sr_q;

  assert_cfg_hold_R2: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(sr_q));
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut
  import lcell_pkg::*;
(
  input  lut_mode_e            mode_i,
  input  in_src_e              f_p_i,
  input  in_src_e              f_q_i,
  input  in_src_e              g_p_i,
  input  in_src_e              g_q_i,
  input  logic                 f_use_e_i,
  input  logic                 g_use_e_i,
  input  logic [LUT_BITS-1:0]  lut_i,
  input  logic                 a_i,
  input  logic                 b_i,
  input  logic                 c_i,
  input  logic                 d_i,
  input  logic                 e_i,
  input  logic                 qx_i,
  input  logic                 qy_i,
  output logic                 f_o,
  output logic                 g_o
);
  function automatic logic pick(in_src_e s, logic b, logic c, logic qx, logic qy);
    case (s)
      SRC_B:   return b;
      SRC_C:   return c;
      SRC_QX:  return qx;
      default: return qy;
    endcase
  endfunction

  logic fp, fq, gp, gq;
  logic [HALF_AW-1:0] split_f_idx, split_g_idx, mux_f_idx, mux_g_idx;
  logic [LUT_AW-1:0]  wide_idx;
  logic               mux_out;

  assign fp = pick(f_p_i, b_i, c_i, qx_i, qy_i);
  assign fq = pick(f_q_i, b_i, c_i, qx_i, qy_i);
  assign gp = pick(g_p_i, b_i, c_i, qx_i, qy_i);
  assign gq = pick(g_q_i, b_i, c_i, qx_i, qy_i);

  assign split_f_idx = {(f_use_e_i ? e_i : d_i), fq, fp, a_i};
  assign split_g_idx = {(g_use_e_i ? e_i : d_i), gq, gp, a_i};
  assign mux_f_idx   = {d_i, fq, fp, a_i};
  assign mux_g_idx   = {d_i, gq, gp, a_i};
  assign wide_idx    = {e_i, d_i, fq, fp, a_i};

  assign mux_out = e_i ? lut_i[{1'b1, mux_g_idx}] : lut_i[{1'b0, mux_f_idx}];

  always_comb begin
    case (mode_i)
      MODE_WIDE: begin
        f_o = lut_i[wide_idx];
        g_o = lut_i[wide_idx];
      end
      MODE_MUXED: begin
        f_o = mux_out;
        g_o = mux_out;
      end
      default: begin
        f_o = lut_i[{1'b0, split_f_idx}];
        g_o = lut_i[{1'b1, split_g_idx}];
      end
    endcase
  end
endmodule

// File: rtl/lcell_ff.sv
module lcell_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (en_i)  q_o <= d_i;
  end

  assert_ec_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    !en_i |=> $stable(q_o));

  assert_rd_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (q_o == 1'b0));
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_clk_i,
  input  logic cfg_en_i,
  input  logic cfg_data_i,
  input  logic cfg_done_i,
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  input  logic e_i,
  input  logic di_i,
  input  logic ec_i,
  input  logic rd_i,
  output logic x_o,
  output logic y_o
);
  localparam int unsigned N_FF = 2;

  logic [CFG_W-1:0] cfg_word;
  cell_cfg_t        cfg;
  logic             f, g;
  logic             k_eff, en_eff, rd_clr;
  logic [N_FF-1:0]  q;
  d_src_e           d_src [N_FF];

  lcell_cfg_chain #(.W(CFG_W)) u_chain (
    .cfg_clk_i (cfg_clk_i),
    .rst_ni    (rst_ni),
    .cfg_en_i  (cfg_en_i),
    .cfg_data_i(cfg_data_i),
    .word_o    (cfg_word)
  );

  assign cfg = cell_cfg_t'(cfg_word);

  lcell_lut u_lut (
    .mode_i   (cfg.mode),
    .f_p_i    (cfg.f_p),
    .f_q_i    (cfg.f_q),
    .g_p_i    (cfg.g_p),
    .g_q_i    (cfg.g_q),
    .f_use_e_i(cfg.f_use_e),
    .g_use_e_i(cfg.g_use_e),
    .lut_i    (cfg.lut),
    .a_i      (a_i),
    .b_i      (b_i),
    .c_i      (c_i),
    .d_i      (d_i),
    .e_i      (e_i),
    .qx_i     (q[0]),
    .qy_i     (q[1]),
    .f_o      (f),
    .g_o      (g)
  );

  assign k_eff  = clk_i ^ cfg.clk_fall;
  assign en_eff = !cfg.ce_used || ec_i;
  assign rd_clr = rd_i && !cfg.rd_block;

  assign d_src[0] = cfg.dx_src;
  assign d_src[1] = cfg.dy_src;

  for (genvar i = 0; i < N_FF; i++) begin : g_ff
    logic d_mux;
    always_comb begin
      case (d_src[i])
        DSRC_F:  d_mux = f;
        DSRC_G:  d_mux = g;
        default: d_mux = di_i;
      endcase
    end

    lcell_ff u_ff (
      .clk_i (k_eff),
      .rst_ni(rst_ni),
      .clr_i (rd_clr),
      .en_i  (en_eff),
      .d_i   (d_mux),
      .q_o   (q[i])
    );
  end

  assign x_o = cfg_done_i && (cfg.x_from_q ? q[0] : f);
  assign y_o = cfg_done_i && (cfg.y_from_q ? q[1] : g);

  assert_di_capture_R7: assert property (@(posedge k_eff) disable iff (!rst_ni || rd_clr)
    (en_eff && cfg.dx_src[1]) |=> (q[0] == $past(di_i)));

  assert_dy_di_capture_R7: assert property (@(posedge k_eff) disable iff (!rst_ni || rd_clr)
    (en_eff && cfg.dy_src[1]) |=> (q[1] == $past(di_i)));
endmodule

// File: tb/tb_lcell_top.sv
module tb_lcell_top;
  localparam int CW = 53;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cfg_clk = 1'b0, cfg_en = 1'b0, cfg_data = 1'b0, cfg_done = 1'b0;
  logic a = 0, b = 0, c = 0, d = 0, e = 0, di = 0, ec = 0, rd = 0;
  logic x, y;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  lcell_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_clk_i(cfg_clk), .cfg_en_i(cfg_en),
    .cfg_data_i(cfg_data), .cfg_done_i(cfg_done),
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .e_i(e),
    .di_i(di), .ec_i(ec), .rd_i(rd), .x_o(x), .y_o(y)
  );

  // bench copy of the configuration fields (layout per R1)
  logic [1:0]  m_mode, m_dx, m_dy, m_fp, m_fq, m_gp, m_gq;
  logic        m_xq, m_yq, m_kf, m_ce, m_rb, m_fe, m_ge;
  logic [31:0] m_lut;

  function automatic logic [CW-1:0] cfg_word();
    return {m_mode, m_xq, m_yq, m_kf, m_ce, m_rb, m_dx, m_dy,
            m_fp, m_fq, m_gp, m_gq, m_fe, m_ge, m_lut};
  endfunction

  function automatic logic sel(logic [1:0] s, logic qx, logic qy);
    case (s)
      2'd0: return b;
      2'd1: return c;
      2'd2: return qx;
      default: return qy;
    endcase
  endfunction

  // expected {F,G} from R3/R4/R5
  function automatic logic [1:0] ref_fg(logic qx, logic qy);
    logic [3:0] fi, gi;
    logic [4:0] wi;
    logic       o;
    case (m_mode)
      2'd1: begin
        wi = {e, d, sel(m_fq, qx, qy), sel(m_fp, qx, qy), a};
        return {m_lut[wi], m_lut[wi]};
      end
      2'd2: begin
        fi = {d, sel(m_fq, qx, qy), sel(m_fp, qx, qy), a};
        gi = {d, sel(m_gq, qx, qy), sel(m_gp, qx, qy), a};
        o  = e ? m_lut[16 + int'(gi)] : m_lut[int'(fi)];
        return {o, o};
      end
      default: begin
        fi = {(m_fe ? e : d), sel(m_fq, qx, qy), sel(m_fp, qx, qy), a};
        gi = {(m_ge ? e : d), sel(m_gq, qx, qy), sel(m_gp, qx, qy), a};
        return {m_lut[int'(fi)], m_lut[16 + int'(gi)]};
      end
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sync();
    @(posedge clk); #5;
  endtask

  task automatic defaults();
    m_mode = 2'd0; m_xq = 0; m_yq = 0; m_kf = 0; m_ce = 1; m_rb = 0;
    m_dx = 2'd0; m_dy = 2'd1; m_fp = 2'd0; m_fq = 2'd1; m_gp = 2'd0; m_gq = 2'd1;
    m_fe = 0; m_ge = 0; m_lut = 32'h0;
    {a, b, c, d, e, di, ec, rd} = '0;
  endtask

  // loads under global reset, then releases reset
  task automatic load();
    logic [CW-1:0] w;
    w = cfg_word();
    sync();
    rst_n = 0; cfg_done = 0; cfg_en = 1;
    for (int i = CW - 1; i >= 0; i--) begin
      cfg_data = w[i];
      #1 cfg_clk = 1;
      #1 cfg_clk = 0;
    end
    cfg_en = 0; cfg_done = 1;
    sync();
    rst_n = 1;
  endtask

  // F = ~QX, G = ~QY, both registered and shown on the outputs
  task automatic toggle_cfg();
    defaults();
    m_fp = 2'd2; m_fq = 2'd0; m_gp = 2'd3; m_gq = 2'd0;
    m_dx = 2'd0; m_dy = 2'd1; m_xq = 1; m_yq = 1; m_ce = 0;
    m_lut = 32'h3333_3333;
  endtask

  task automatic t_reset_done();
    chk("R12 reset x", x, 1'b0);
    chk("R12 reset y", y, 1'b0);
    defaults();
    m_lut = 32'hFFFF_FFFF;
    load();
    #1 chk("R1 all-ones word x", x, 1'b1);
    chk("R1 all-ones word y", y, 1'b1);
    cfg_done = 0;
    #1 chk("R12 done low x", x, 1'b0);
    chk("R12 done low y", y, 1'b0);
    cfg_done = 1;
  endtask

  task automatic t_sweep(input string req);
    logic [1:0] ex;
    load();
    for (int v = 0; v < 32; v++) begin
      {e, d, c, b, a} = 5'(v);
      #1;
      ex = ref_fg(1'b0, 1'b0);
      chk({req, " F on x (R11)"}, x, ex[1]);
      chk({req, " G on y (R11)"}, y, ex[0]);
    end
    {a, b, c, d, e} = '0;
  endtask

  task automatic t_modes();
    defaults();
    m_mode = 2'd0; m_fp = 2'd0; m_fq = 2'd1; m_fe = 0;
    m_gp = 2'd1; m_gq = 2'd0; m_ge = 1; m_lut = 32'h6D2B_C1F4;
    t_sweep("R3 split");
    m_mode = 2'd3; m_lut = 32'h1E87_5AC3;
    t_sweep("R3 split alt code");
    defaults();
    m_mode = 2'd1; m_fp = 2'd1; m_fq = 2'd0; m_lut = 32'h9669_6996;
    t_sweep("R4 wide parity");
    m_lut = 32'h8000_0000;
    t_sweep("R4 wide and");
    defaults();
    m_mode = 2'd2; m_fp = 2'd0; m_fq = 2'd1; m_gp = 2'd1; m_gq = 2'd0;
    m_lut = 32'h3C5A_F00F;
    t_sweep("R5 muxed");
  endtask

  task automatic t_toggle();
    logic exp;
    toggle_cfg();
    load();
    chk("R10 after load x", x, 1'b0);
    exp = 0;
    for (int i = 0; i < 4; i++) begin
      sync();
      exp = ~exp;
      chk("R13 R7 QX toggles via F", x, exp);
      chk("R13 R7 QY toggles via G", y, exp);
      chk("R6 ec ignored when tied on", x, exp);
    end
  endtask

  task automatic t_enable();
    toggle_cfg();
    m_ce = 1;
    load();
    ec = 0;
    sync(); chk("R6 hold ec=0 edge1", x, 1'b0);
    sync(); chk("R6 hold ec=0 edge2", y, 1'b0);
    ec = 1;
    sync(); chk("R6 load ec=1", x, 1'b1);
    ec = 0;
    sync(); chk("R6 hold after ec drop", x, 1'b1);
    chk("R6 hold after ec drop y", y, 1'b1);
    ec = 0;
  endtask

  task automatic t_edge(input logic fall);
    defaults();
    m_dx = 2'd2; m_dy = 2'd3; m_xq = 1; m_yq = 1; m_ce = 0; m_kf = fall;
    load();
    @(posedge clk); #2 di = 1;
    #5 chk("R8 before falling edge x", x, 1'b0);
    chk("R8 before falling edge y", y, 1'b0);
    #8 chk(fall ? "R8 falling edge captures" : "R8 rising mode ignores fall", x, fall);
    chk("R7 DI code 3 on QY", y, fall);
    sync();
    chk("R7 DI code 2 on QX", x, 1'b1);
    chk("R7 DI on QY", y, 1'b1);
    di = 0;
    sync();
    chk("R7 DI zero on QX", x, 1'b0);
  endtask

  task automatic t_direct_clear();
    toggle_cfg();
    load();
    sync(); chk("R9 pre clear x", x, 1'b1);
    rd = 1;
    #2 chk("R9 async clear x", x, 1'b0);
    chk("R9 async clear y", y, 1'b0);
    sync(); chk("R9 clear holds over edge", x, 1'b0);
    rd = 0;
    sync(); chk("R9 resumes after clear", x, 1'b1);
    toggle_cfg();
    m_rb = 1;
    load();
    sync(); chk("R9 blocked pre x", x, 1'b1);
    rd = 1;
    #2 chk("R9 blocked clear ignored", x, 1'b1);
    sync(); chk("R9 blocked still toggles", x, 1'b0);
    rd = 0;
  endtask

  task automatic t_global_reset();
    toggle_cfg();
    load();
    sync(); chk("R10 pre reset", x, 1'b1);
    rst_n = 0;
    #2 chk("R10 async reset x", x, 1'b0);
    chk("R10 async reset y", y, 1'b0);
    sync(); rst_n = 1;
    sync(); chk("R10 runs after reset", x, 1'b1);
  endtask

  task automatic t_cfg_shift();
    defaults();
    m_lut = 32'hFFFF_FFFF;
    load();
    cfg_en = 0;
    for (int i = 0; i < 12; i++) begin
      cfg_data = i[0];
      #1 cfg_clk = 1;
      #1 cfg_clk = 0;
    end
    #1 chk("R2 shift disabled keeps x", x, 1'b1);
    chk("R2 shift disabled keeps y", y, 1'b1);
    defaults();
    load();
    #1 chk("R1 reload zero word x", x, 1'b0);
    chk("R1 reload zero word y", y, 1'b0);
  endtask

  initial begin
    #1;
    t_reset_done();
    t_modes();
    t_toggle();
    t_enable();
    t_edge(1'b0);
    t_edge(1'b1);
    t_direct_clear();
    t_global_reset();
    t_cfg_shift();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule